// File: doc/BRIEF.md
# Auxiliary Channel Request Engine

This block sends one request packet over a half-duplex auxiliary side channel and captures the reply. Software works through a small register window. It loads a request of up to 20 bytes into five 32-bit data words, then writes a control word that holds the request length and sets the send-busy bit. The engine streams the request bytes to a byte-wide PHY port and then listens on the receive port. It places the reply bytes back into the same data words. Finally it reports completion through the control word, where the length field now holds the reply length.

The PHY side is modelled as two byte streams with a last-byte marker; the line encoding is outside the block. The transmit stream is valid/ready. While `tx_valid` is high and `tx_ready` is low, the engine holds `tx_data` and `tx_last` unchanged. The receive stream is also valid/ready. The engine keeps `rx_ready` high for the whole reply window, from the cycle after the last request byte is accepted until the reply's last byte. The sender may leave idle gaps. A byte counts only in a cycle where both `rx_valid` and `rx_ready` are high, and bytes offered outside the window are not taken.

Register map: address 0 is the control word and addresses 1 to 5 are data words 0 to 4. Control word fields:
- bit 31: send-busy
- bit 30: done
- bit 29: timeout error
- bit 28: receive error
- bits 24:20: length
- bits 15:0: reply timeout limit in cycles

All other control bits read as zero.

Top module: `aux_req_engine`

## Requirements
- R1: After reset every register reads zero. Data words at addresses 1 to 5 read back what was written while idle. Addresses 0 and 6 to 7 are not data words, and reads of addresses 6 and 7 return zero.
- R2: While idle, a control write loads the length field (bits 24:20) and the timeout limit (bits 15:0), and both read back unchanged. Bits 27:25 and 19:16 read zero.
- R3: A control write with bit 31 set and a length of 1 to 20 starts a request. The write clears done and both error bits, busy reads one from the next cycle, and `tx_valid` rises in that same cycle.
- R4: Request byte k is taken from data word k/4, at bits [31-8*(k mod 4) -: 8], so the most significant byte of word 0 goes first. Bytes go out in order 0 to length-1. `tx_last` marks byte length-1. Data and last are held stable while `tx_ready` is low.
- R5: `rx_ready` is high from the cycle after the last request byte is accepted until the reply's last byte is accepted. `rx_ready` and `tx_valid` are never high together. Reply byte k is written to the same byte position as request byte k. Bytes at or beyond the reply length keep their request contents.
- R6: One cycle after the reply's last byte is accepted, busy clears and done sets on the same edge. The length field then holds the number of reply bytes. At most one of done, timeout error and receive error is ever set.
- R7: If no reply byte is accepted within the limit's number of reply-window cycles (a limit of 0 acts as 1), the timeout bit sets. On that same edge busy and `rx_ready` clear. If a byte arrives in the last allowed cycle, that byte is taken and no timeout occurs.
- R8: A reply longer than 20 bytes is consumed up to its last byte. Then the receive-error bit sets and busy clears, while the data words and the length field are left unchanged.
- R9: A start write with length 0 or above 20 sets the receive-error bit on its edge. The same write clears done and timeout. Busy never sets and no byte is sent.
- R10: While idle, writing one to control bit 30, 29 or 28 clears that bit. Writing zero leaves it unchanged.
- R11: While busy, including the completion cycle, writes to every address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Write address (0 control, 1-5 data) |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 3 | Read address |
| reg_rd_data | output | 32 | Read data, combinational from the address |
| tx_valid | output | 1 | Request byte available |
| tx_ready | input | 1 | PHY accepts the request byte |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final request byte |
| rx_valid | input | 1 | Reply byte available |
| rx_ready | output | 1 | Engine is in the reply window |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final reply byte |

## Verification
Two events can fall in the same cycle: the expiry of the reply timeout and the arrival of the first reply byte. The bench reaches this case by holding the receive port idle for exactly one cycle fewer than the limit and offering the first byte in the final allowed cycle. The case is judged correct when the byte is stored and the request ends in done with no timeout. The bench also lands a software write on the completion cycle and on the transmit and wait phases. A write there must change nothing, while the reply still commits. Every cycle the bench compares all outputs and a rotating register read against a behavioural model.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  localparam int AUX_WORDS = 5;
  localparam int AUX_BYTES = AUX_WORDS * 4;
  localparam int LEN_W     = $clog2(AUX_BYTES + 1);
  localparam int CNT_W     = LEN_W + 1;
  localparam int ADDR_W    = $clog2(AUX_WORDS + 1);
  localparam int WIDX_W    = $clog2(AUX_WORDS);
  localparam int TMO_W     = 16;

  localparam int BUSY_B  = 31;
  localparam int DONE_B  = 30;
  localparam int TMO_B   = 29;
  localparam int RXE_B   = 28;
  localparam int LEN_LSB = 20;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TX,
    PH_WAIT,
    PH_RX,
    PH_FIN
  } aux_phase_e;
endpackage

// File: rtl/aux_seq.sv
module aux_seq
  import aux_req_pkg::*;
#(
  parameter int BYTES = AUX_BYTES,
  parameter int LW    = LEN_W,
  parameter int CW    = CNT_W,
  parameter int TW    = TMO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] req_len,
  input  logic [TW-1:0] limit,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic          rx_last,
  output logic          busy,
  output logic          tx_valid,
  output logic          tx_last,
  output logic [LW-1:0] tx_idx,
  output logic          rx_ready,
  output logic          rx_take,
  output logic [CW-1:0] rx_idx,
  output logic          fin_ok,
  output logic          fin_ovf,
  output logic          fin_tmo,
  output logic [LW-1:0] rx_len
);
  aux_phase_e    ph_q;
  logic [LW-1:0] idx_q;
  logic [TW-1:0] timer_q;
  logic [CW-1:0] cnt_q;
  logic          over_q;

  assign busy     = (ph_q != PH_IDLE);
  assign tx_valid = (ph_q == PH_TX);
  assign tx_last  = (idx_q == req_len - 1'b1);
  assign tx_idx   = idx_q;
  assign rx_ready = (ph_q == PH_WAIT) || (ph_q == PH_RX);
  assign rx_take  = rx_ready && rx_valid;
  assign rx_idx   = cnt_q;
  assign over_q   = (cnt_q > CW'(BYTES));
  assign fin_ok   = (ph_q == PH_FIN) && !over_q;
  assign fin_ovf  = (ph_q == PH_FIN) && over_q;
  assign fin_tmo  = (ph_q == PH_WAIT) && !rx_valid &&
                    (({1'b0, timer_q} + 1'b1) >= {1'b0, limit});
  assign rx_len   = cnt_q[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      idx_q   <= '0;
      timer_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q  <= PH_TX;
          idx_q <= '0;
          cnt_q <= '0;
        end
        PH_TX: if (tx_ready) begin
          if (tx_last) begin
            ph_q    <= PH_WAIT;
            timer_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_WAIT: begin
          if (rx_valid) begin
            cnt_q <= CW'(1);
            ph_q  <= rx_last ? PH_FIN : PH_RX;
          end else if (fin_tmo) begin
            ph_q <= PH_IDLE;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        PH_RX: if (rx_valid) begin
          if (!over_q) cnt_q <= cnt_q + 1'b1;
          if (rx_last) ph_q <= PH_FIN;
        end
        PH_FIN:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_data_file.sv
module aux_data_file
  import aux_req_pkg::*;
#(
  parameter int WORDS = AUX_WORDS,
  parameter int LW    = LEN_W,
  parameter int CW    = CNT_W,
  parameter int WI    = WIDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WI-1:0] wr_word,
  input  logic [31:0]   wr_data,
  input  logic [WI-1:0] rd_word,
  output logic [31:0]   rd_data,
  input  logic [LW-1:0] tx_idx,
  output logic [7:0]    tx_byte,
  input  logic          rx_take,
  input  logic [CW-1:0] rx_idx,
  input  logic [7:0]    rx_byte,
  input  logic          commit,
  input  logic [LW-1:0] commit_len
);
  localparam int NB = WORDS * 4;

  logic [7:0]  byte_q [NB];
  logic [7:0]  shad_q [NB];
  logic [31:0] word_v [WORDS];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int WSEL = b / 4;
    localparam int SH   = 24 - 8 * (b % 4);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[b] <= '0;
        shad_q[b] <= '0;
      end else begin
        if (wr_en && wr_word == WI'(WSEL))
          byte_q[b] <= wr_data[SH +: 8];
        else if (commit && LW'(b) < commit_len)
          byte_q[b] <= shad_q[b];
        if (rx_take && rx_idx == CW'(b))
          shad_q[b] <= rx_byte;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_v[w] = {byte_q[4*w], byte_q[4*w+1], byte_q[4*w+2], byte_q[4*w+3]};
  end

  assign rd_data = word_v[rd_word];
  assign tx_byte = byte_q[tx_idx];
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
  import aux_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [31:0]       reg_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last
);
  logic             busy, done_q, tmo_q, rxe_q;
  logic [LEN_W-1:0] len_q, new_len, rx_len;
  logic [TMO_W-1:0] lim_q;
  logic             ctrl_wr, data_wr, start_req, len_ok, start;
  logic             rx_take, fin_ok, fin_ovf, fin_tmo;
  logic [LEN_W-1:0] tx_idx;
  logic [CNT_W-1:0] rx_idx;
  logic [31:0]      word_rd, ctrl_word;
  logic [ADDR_W-1:0] wr_m1, rd_m1;
  logic             unused_ok;

  assign unused_ok = ^{reg_wr_data[27:25], reg_wr_data[19:16]};

  assign ctrl_wr   = reg_wr_en && !busy && reg_wr_addr == '0;
  assign data_wr   = reg_wr_en && !busy && reg_wr_addr != '0 &&
                     reg_wr_addr <= ADDR_W'(AUX_WORDS);
  assign new_len   = reg_wr_data[LEN_LSB +: LEN_W];
  assign start_req = ctrl_wr && reg_wr_data[BUSY_B];
  assign len_ok    = new_len != '0 && new_len <= LEN_W'(AUX_BYTES);
  assign start     = start_req && len_ok;
  assign wr_m1     = reg_wr_addr - 1'b1;
  assign rd_m1     = reg_rd_addr - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      rxe_q  <= 1'b0;
      len_q  <= '0;
      lim_q  <= '0;
    end else if (ctrl_wr) begin
      len_q <= new_len;
      lim_q <= reg_wr_data[TMO_W-1:0];
      if (start_req) begin
        done_q <= 1'b0;
        tmo_q  <= 1'b0;
        rxe_q  <= !len_ok;
      end else begin
        done_q <= done_q & ~reg_wr_data[DONE_B];
        tmo_q  <= tmo_q  & ~reg_wr_data[TMO_B];
        rxe_q  <= rxe_q  & ~reg_wr_data[RXE_B];
      end
    end else begin
      if (fin_ok) begin
        done_q <= 1'b1;
        len_q  <= rx_len;
      end
      if (fin_ovf) rxe_q <= 1'b1;
      if (fin_tmo) tmo_q <= 1'b1;
    end
  end

  aux_seq u_seq (
    .clk, .rst_n, .start,
    .req_len  (len_q),
    .limit    (lim_q),
    .tx_ready, .rx_valid, .rx_last,
    .busy, .tx_valid, .tx_last, .tx_idx,
    .rx_ready, .rx_take, .rx_idx,
    .fin_ok, .fin_ovf, .fin_tmo, .rx_len
  );

  aux_data_file u_data (
    .clk, .rst_n,
    .wr_en      (data_wr),
    .wr_word    (wr_m1[WIDX_W-1:0]),
    .wr_data    (reg_wr_data),
    .rd_word    (rd_m1[WIDX_W-1:0]),
    .rd_data    (word_rd),
    .tx_idx,
    .tx_byte    (tx_data),
    .rx_take, .rx_idx,
    .rx_byte    (rx_data),
    .commit     (fin_ok),
    .commit_len (rx_len)
  );

  assign ctrl_word = {busy, done_q, tmo_q, rxe_q, 3'b000, len_q, 4'b0000, lim_q};

  always_comb begin
    if (reg_rd_addr == '0)                                reg_rd_data = ctrl_word;
    else if (reg_rd_addr <= ADDR_W'(AUX_WORDS))           reg_rd_data = word_rd;
    else                                                  reg_rd_data = '0;
  end
endmodule

module aux_req_checker
  import aux_req_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             rx_ready,
  input logic             busy,
  input logic             done,
  input logic             tmo,
  input logic             rxe,
  input logic             reg_wr_en,
  input logic [TMO_W-1:0] lim
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4
  AST_START_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_valid); // R3
  AST_NO_DUAL_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready)); // R5
  AST_END_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || tmo || rxe)); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, tmo, rxe})); // R6
  AST_TMO_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> !rx_ready && !busy); // R7
  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr_en |=> $stable(lim)); // R11
endmodule

bind aux_req_engine aux_req_checker u_chk (
  .clk, .rst_n, .tx_valid, .tx_ready, .tx_data, .tx_last, .rx_ready,
  .busy, .done(done_q), .tmo(tmo_q), .rxe(rxe_q), .reg_wr_en, .lim(lim_q)
);

// File: tb/aux_req_engine_test.sv
`timescale 1ns/1ps
module aux_req_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        tx_valid, tx_last, rx_ready;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;

  always #4 clk = ~clk;

  aux_req_engine uut (.*);

  // behavioural reference model
  logic [7:0] m_data [20];
  logic [7:0] m_sh [20];
  bit m_done, m_tmo, m_rxe;
  int m_ph, m_len, m_lim, m_idx, m_tmr, m_cnt;
  int vectors = 0, errors = 0, rd_sel = 0;
  string cur_req = "R1";

  function automatic logic [31:0] exp_rd(input int a);
    if (a == 0)
      return {(m_ph != 0), m_done, m_tmo, m_rxe, 3'b000, 5'(m_len), 4'b0000, 16'(m_lim)};
    if (a >= 1 && a <= 5)
      return {m_data[4*(a-1)], m_data[4*(a-1)+1], m_data[4*(a-1)+2], m_data[4*(a-1)+3]};
    return 32'h0;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("tx_valid", 32'(tx_valid), 32'(m_ph == 1));
    chk("rx_ready", 32'(rx_ready), 32'(m_ph == 2 || m_ph == 3));
    if (m_ph == 1) begin
      chk("tx_data", 32'(tx_data), 32'(m_data[m_idx]));
      chk("tx_last", 32'(tx_last), 32'(m_idx == m_len - 1));
    end
    chk($sformatf("rd[%0d]", reg_rd_addr), reg_rd_data, exp_rd(int'(reg_rd_addr)));
  endtask

  task automatic model_step();
    case (m_ph)
      0: if (reg_wr_en) begin
        if (reg_wr_addr == 0) begin
          m_len = int'(reg_wr_data[24:20]);
          m_lim = int'(reg_wr_data[15:0]);
          if (reg_wr_data[31]) begin
            m_done = 0; m_tmo = 0;
            if (m_len >= 1 && m_len <= 20) begin
              m_rxe = 0; m_ph = 1; m_idx = 0; m_cnt = 0;
            end else m_rxe = 1;
          end else begin
            if (reg_wr_data[30]) m_done = 0;
            if (reg_wr_data[29]) m_tmo = 0;
            if (reg_wr_data[28]) m_rxe = 0;
          end
        end else if (reg_wr_addr <= 5) begin
          for (int k = 0; k < 4; k++)
            m_data[4*(reg_wr_addr-1)+k] = reg_wr_data[31-8*k -: 8];
        end
      end
      1: if (tx_ready) begin
        if (m_idx == m_len - 1) begin m_ph = 2; m_tmr = 0; end
        else m_idx++;
      end
      2: if (rx_valid) begin
        m_sh[0] = rx_data; m_cnt = 1; m_ph = rx_last ? 4 : 3;
      end else if (m_tmr + 1 >= m_lim) begin
        m_tmo = 1; m_ph = 0;
      end else m_tmr++;
      3: if (rx_valid) begin
        if (m_cnt < 20) m_sh[m_cnt] = rx_data;
        if (m_cnt <= 20) m_cnt++;
        if (rx_last) m_ph = 4;
      end
      default: begin
        if (m_cnt <= 20) begin
          for (int k = 0; k < m_cnt; k++) m_data[k] = m_sh[k];
          m_len = m_cnt; m_done = 1;
        end else m_rxe = 1;
        m_ph = 0;
      end
    endcase
  endtask

  task automatic cyc();
    reg_rd_addr = 3'(rd_sel % 8);
    rd_sel++;
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    cyc();
    reg_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic start(input int len, input int lim);
    cur_req = "R3";
    wr(3'd0, 32'h8000_0000 | (32'(len) << 20) | 32'(lim));
  endtask

  task automatic run_tx(input int stall_mod);
    cur_req = "R4";
    for (int i = 0; m_ph == 1; i++) begin
      tx_ready = (stall_mod == 0) ? 1'b1 : ((i % stall_mod) != 0);
      cyc();
    end
    tx_ready = 1'b1;
  endtask

  task automatic reply(input int n, input int seed, input bit gaps);
    cur_req = "R5";
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = 8'(seed + 7 * i); rx_last = (i == n - 1);
      cyc();
      if (gaps && (i % 2 == 1)) begin rx_valid = 1'b0; rx_last = 1'b0; cyc(); end
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic finish_up(input string req);
    cur_req = req;
    while (m_ph != 0) cyc();
    idle(8);
  endtask

  initial begin
    for (int k = 0; k < 20; k++) begin m_data[k] = '0; m_sh[k] = '0; end
    m_ph = 0; m_len = 0; m_lim = 0; m_idx = 0; m_tmr = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values then data word write/readback
    cur_req = "R1";
    idle(8);
    for (int w = 1; w <= 5; w++) wr(3'(w), 32'h11223344 * w + 32'h0F0E0D0C);
    idle(8);
    // R2 control fields without start
    cur_req = "R2";
    wr(3'd0, 32'h0E70_1234 | (32'd7 << 20));
    idle(8);
    // R3 R4 R5 R6 short request, short reply
    start(6, 30); run_tx(0); idle(3); reply(4, 8'h51, 0); finish_up("R6");
    // R4 back-pressure, gapped reply
    start(9, 40); run_tx(3); reply(9, 8'h20, 1); finish_up("R6");
    // R7 timeout, limit 5 and limit 0
    start(2, 5); run_tx(0); finish_up("R7");
    start(1, 0); run_tx(2); finish_up("R7");
    // R7 byte in the final allowed cycle wins over the timeout
    start(3, 4); run_tx(0); cur_req = "R7"; idle(3); reply(2, 8'hC3, 0); finish_up("R7");
    // R10 clear done: a zero in bit 30 keeps it, a one clears it
    cur_req = "R10";
    wr(3'd0, 32'h0000_0010); idle(8);
    wr(3'd0, 32'h4000_0010); idle(8);
    // R8 overlong reply leaves data and length untouched
    start(1, 20); run_tx(0); reply(23, 8'h90, 0); finish_up("R8");
    // R6 maximum-size request and reply
    for (int w = 1; w <= 5; w++) wr(3'(w), 32'hA5A5_0000 + 32'(w));
    start(20, 50); run_tx(4); reply(20, 8'h03, 1); finish_up("R6");
    // R9 illegal lengths
    start(0, 9); finish_up("R9");
    start(25, 9); finish_up("R9");
    // R10 wrong-bit clear keeps the receive error, right bit clears it
    cur_req = "R10";
    wr(3'd0, 32'h2000_0009); idle(8);
    wr(3'd0, 32'h1000_0009); idle(8);
    // R11 writes during transmit, wait and completion are ignored
    start(4, 12);
    cur_req = "R11";
    tx_ready = 1'b0;
    wr(3'd2, 32'hDEAD_BEEF);
    tx_ready = 1'b1;
    run_tx(0);
    cur_req = "R11";
    wr(3'd0, 32'h0000_0333); idle(2);
    rx_valid = 1'b1; rx_data = 8'h77; rx_last = 1'b1; cyc();
    rx_valid = 1'b0; rx_last = 1'b0;
    wr(3'd1, 32'h1234_5678);
    finish_up("R11");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule